// File: doc/BRIEF.md
# Subtractive GCD Engine with Binary Pre-Scaling

This block is a multicycle unit that finds the greatest common divisor of two unsigned integers (8 bits by default). A one-cycle start pulse captures both operands into working registers. A controller steps through a short loop. While both working values are even, it halves them together and counts each halving. Once at least one value is odd, it subtracts the smaller value from the larger and leaves the smaller one as it was. It repeats this until the two values match. The matching value is shifted left by the halving count and written into a result register, and a one-cycle completion pulse is raised.

The halving pre-step shortens the subtraction loop for operands that share large powers of two, such as 128 and 64. A zero operand skips the loop entirely. The unit has an asynchronous active-low reset, which is released synchronously inside the block. It also has a synchronous clear that aborts any operation in progress.

Top module: `sub_gcd_unit`

## Requirements
- R1: After reset release, `busy`, `done` and `result` are all 0.
- R2: A `go` pulse while idle starts an operation. `busy` is high from the cycle after the sampling edge of `go` until the completion cycle. Changes to `opnd_a` and `opnd_b` after the load cycle have no effect on the result. `busy` falls only together with `done` or because of a clear.
- R3: For two nonzero operands, `result` equals their greatest common divisor.
- R4: Operands that share factors of two are halved together and rescaled at the end. Pairs such as (128,64), (128,128) and (192,64) complete with the correct result.
- R5: If exactly one operand is zero, `result` equals the other operand. If both are zero, `result` is 0.
- R6: `done` is high for exactly one cycle, and in that cycle the new `result` is already visible. Between completions, `result` holds its value.
- R7: A `go` pulse while `busy` is high is ignored. It neither restarts the current operation nor queues a second one.
- R8: When `clr` is high at a clock edge, the next cycle shows `busy`=0, `done`=0 and `result`=0.
- R9: Every operation completes within 4·2^W cycles of its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear: returns to idle and zeroes the working and result registers |
| go | input | 1 | Start request, sampled only while idle |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Last computed GCD |

## Verification
A corrupted working value or a wrong step direction changes the value that the loop converges on. The bench sees this as a wrong `result` in the same cycle that `done` rises. A halving count that goes wrong shows as a result that is off by a power of two, which the power-of-two pairs expose. A controller that leaves idle wrongly, or never reaches completion, shows within one cycle as an unexpected `busy` level, or as a missing `done` within the latency bound of R9. A clear that fails to zero a register shows one cycle after the clear, as a nonzero `result`.

// File: rtl/sub_gcd_pkg.sv
package sub_gcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_TEST  = 3'd2,
    ST_HALVE = 3'd3,
    ST_SUB   = 3'd4,
    ST_FIN   = 3'd5
  } gcd_state_e;

  typedef struct packed {
    logic load;
    logic halve;
    logic sub;
    logic fin;
  } gcd_ctrl_t;

  typedef struct packed {
    logic eq;
    logic lt;
    logic both_even;
    logic any_zero;
  } gcd_flags_t;

endpackage

// File: rtl/sub_gcd_rst_sync.sv
module sub_gcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sub_gcd_dpath.sv
module sub_gcd_dpath
  import sub_gcd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  gcd_ctrl_t    ctl,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output gcd_flags_t   flags,
  output logic [W-1:0] result,
  output logic         done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  a_q, a_d;
  logic [W-1:0]  b_q, b_d;
  logic [CW-1:0] sh_q, sh_d;
  logic [W-1:0]  res_q, res_d;
  logic          done_q, done_d;

  // compare flags seen by the controller
  always_comb begin
    flags.eq        = (a_q == b_q);
    flags.lt        = (a_q < b_q);
    flags.both_even = ~a_q[0] & ~b_q[0];
    flags.any_zero  = (a_q == '0) | (b_q == '0);
  end

  // next values for the working registers
  always_comb begin
    a_d  = a_q;
    b_d  = b_q;
    sh_d = sh_q;
    if (ctl.load) begin
      a_d  = opnd_a;
      b_d  = opnd_b;
      sh_d = '0;
    end else if (ctl.halve) begin
      a_d  = a_q >> 1;
      b_d  = b_q >> 1;
      sh_d = sh_q + CW'(1);
    end else if (ctl.sub) begin
      if (flags.lt) b_d = b_q - a_q;
      else          a_d = a_q - b_q;
    end
  end

  // result and completion pulse
  always_comb begin
    res_d  = res_q;
    done_d = 1'b0;
    if (ctl.fin) begin
      done_d = 1'b1;
      if (flags.any_zero) res_d = a_q | b_q;
      else                res_d = a_q << sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      sh_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      a_q    <= '0;
      b_q    <= '0;
      sh_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      sh_q   <= sh_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;

endmodule

// File: rtl/sub_gcd_ctrl.sv
module sub_gcd_ctrl
  import sub_gcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       go,
  input  gcd_flags_t flags,
  output gcd_ctrl_t  ctl,
  output logic       busy
);

  gcd_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_TEST;
      ST_TEST: begin
        if (flags.any_zero || flags.eq) state_d = ST_FIN;
        else if (flags.both_even)       state_d = ST_HALVE;
        else                            state_d = ST_SUB;
      end
      ST_HALVE: state_d = ST_TEST;
      ST_SUB:   state_d = ST_TEST;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= ST_IDLE;
    else if (clr) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // decoded controls
  always_comb begin
    ctl.load  = (state_q == ST_LOAD);
    ctl.halve = (state_q == ST_HALVE);
    ctl.sub   = (state_q == ST_SUB);
    ctl.fin   = (state_q == ST_FIN);
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sub_gcd_unit.sv
module sub_gcd_unit
  import sub_gcd_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         go,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  logic       rst_int_n;
  gcd_ctrl_t  ctl;
  gcd_flags_t flags;

  sub_gcd_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sub_gcd_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (clr),
    .go    (go),
    .flags (flags),
    .ctl   (ctl),
    .busy  (busy)
  );

  sub_gcd_dpath #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (clr),
    .ctl    (ctl),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .flags  (flags),
    .result (result),
    .done   (done)
  );

endmodule

// File: rtl/sub_gcd_chk.sv
module sub_gcd_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);

  localparam int LIMIT = 4 << W;
  localparam int LW    = W + 4;

  logic [LW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_cnt <= '0;
    else if (!busy) run_cnt <= '0;
    else            run_cnt <= run_cnt + LW'(1);
  end

  assert_clr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !done && result == '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(clr)) |-> $stable(result));

  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(clr)) |-> done);

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_cnt) < LIMIT));

endmodule

bind sub_gcd_unit sub_gcd_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr    (clr),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/sub_gcd_unit_test.sv
module sub_gcd_unit_test;

  localparam int W     = 8;
  localparam int LIMIT = 4 << W;

  logic         clk;
  logic         rst_n;
  logic         clr;
  logic         go;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int n_chk;
  int n_bad;

  sub_gcd_unit #(.W(W)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .go     (go),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ref_gcd(input int x, input int y);
    int p = x;
    int q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start one operation and wait for done; returns result and latency
  task automatic run_op(input int a, input int b, output int res, output int lat);
    @(negedge clk);
    opnd_a = W'(a);
    opnd_b = W'(b);
    go     = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1, "R2 busy after go", int'(busy), 1);
    lat = 1;
    while (!done && lat < 2 * LIMIT) begin
      @(negedge clk);
      lat++;
    end
    res = int'(result);
  endtask

  task automatic op_and_check(input int a, input int b, input string req);
    int res, lat, held;
    run_op(a, b, res, lat);
    check(res == ref_gcd(a, b), req, res, ref_gcd(a, b));
    check(lat <= LIMIT, "R9 latency", lat, LIMIT);
    @(negedge clk);
    held = int'(result);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    check(held == res, "R6 result held", held, res);
  endtask

  task automatic t_reset();
    rst_n  = 1'b0;
    clr    = 1'b0;
    go     = 1'b0;
    opnd_a = '0;
    opnd_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(result == '0, "R1 result", int'(result), 0);
  endtask

  task automatic t_basic();
    op_and_check(12, 18, "R3 12,18");
    op_and_check(15, 93, "R3 15,93");
    op_and_check(35, 21, "R3 35,21");
    op_and_check(255, 1, "R3 255,1");
    op_and_check(1, 255, "R3 1,255");
    op_and_check(97, 89, "R3 primes");
    op_and_check(200, 200, "R3 equal");
  endtask

  task automatic t_pow2();
    op_and_check(128, 64, "R4 128,64");
    op_and_check(128, 128, "R4 128,128");
    op_and_check(192, 64, "R4 192,64");
    op_and_check(96, 160, "R4 96,160");
    op_and_check(2, 254, "R4 2,254");
    op_and_check(224, 48, "R4 224,48");
  endtask

  task automatic t_zero();
    op_and_check(0, 37, "R5 0,37");
    op_and_check(64, 0, "R5 64,0");
    op_and_check(0, 0, "R5 0,0");
  endtask

  task automatic t_go_busy();
    int lat;
    @(negedge clk);
    opnd_a = 8'd255;
    opnd_b = 8'd2;
    go     = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (6) @(negedge clk);
    // new operands and a second go while busy: both must be ignored
    opnd_a = 8'd4;
    opnd_b = 8'd6;
    go     = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1, "R7 still busy", int'(busy), 1);
    lat = 0;
    while (!done && lat < 2 * LIMIT) begin
      @(negedge clk);
      lat++;
    end
    check(int'(result) == 1, "R7 R2 first operands kept", int'(result), 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7 no queued start", int'(busy), 0);
  endtask

  task automatic t_clear();
    op_and_check(48, 36, "R3 before clear");
    @(negedge clk);
    opnd_a = 8'd200;
    opnd_b = 8'd3;
    go     = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (5) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(busy == 1'b0, "R8 busy", int'(busy), 0);
    check(done == 1'b0, "R8 done", int'(done), 0);
    check(result == '0, "R8 result", int'(result), 0);
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R8 no late done", int'(done), 0);
    op_and_check(21, 14, "R3 after clear");
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op_and_check(int'(lfsr[7:0]), int'(lfsr[15:8]), "R3 sweep");
    end
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_basic();
    t_pow2();
    t_zero();
    t_go_busy();
    t_clear();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule